// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Enable

This block sits between a set of peripheral request lines and a processor core. It decides whether an interrupt may be taken, picks the most urgent pending source, and shows the core a vector number together with the address of that vector's table entry. Maskable requests pass only while the global enable bit of an 8-bit status word is set. A separate nonmaskable input bypasses that bit and wins over every maskable source.

When the core accepts an interrupt, the controller clears the global enable, so that a handler cannot be interrupted. It also pulses an acknowledge back to the chosen peripheral, so that the peripheral can drop its flag. When the core signals the end of the handler, the enable comes back.

Software disables and enables interrupts through two strobes. These strobes go through a disable-depth counter, so nested critical regions release interrupts only when the outermost region ends. At reset the counter holds one level of disable. The counter saturates at both ends, and it reports an error when a strobe tries to move it past either end.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status word is 0x00, the disable depth is 1, `irq_valid`, `src_ack` and `nest_err` are low.
- R2: Status bit 7 is the global enable. While it is 0 and no nonmaskable event is pending, `irq_valid` stays low whatever `irq_req` holds. While it is 1, any set `irq_req` bit raises `irq_valid`, unless a handler is active.
- R3: Among set `irq_req` bits, the lowest index wins. Source index i has vector number FIRST_VEC+i (default FIRST_VEC=2).
- R4: `vec_addr` is 2*(vec_num-1). The nonmaskable source has vector number 1, which gives address 0.
- R5: `core_ack` while `irq_valid` is high takes the interrupt. On the next cycle status bit 7 is 0, bit 6 (handler active) is 1, and `irq_valid` stays low until the return. `core_ack` while `irq_valid` is low has no effect.
- R6: One cycle after a take, `src_ack` is high for exactly one cycle. `src_ack_idx` then carries the taken source index, or `src_ack_nmi` is 1 for the nonmaskable source.
- R7: `core_ret` during a handler clears status bits 6 and 5 on the next cycle. It sets bit 7 again if the disable depth is zero. `core_ret` with no handler active has no effect.
- R8: The nonmaskable input is edge detected. A rising edge makes it pending one cycle later, regardless of bit 7. It has priority over maskable requests, status bit 5 marks its handler, and one rising edge is taken only once.
- R9: `gie_clr` adds one to the disable depth and `gie_set` subtracts one. Both strobes in the same cycle leave the depth unchanged. Bit 7 reads 1 only when the depth is zero and no handler is active.
- R10: The depth saturates at 0 and at 2^DEPTH_W-1 (default 15). A strobe that would pass either limit leaves the depth unchanged and pulses `nest_err` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Maskable request levels from peripherals |
| nmi_in | input | 1 | Nonmaskable request, rising-edge sensitive |
| gie_set | input | 1 | Enable strobe (decrements disable depth) |
| gie_clr | input | 1 | Disable strobe (increments disable depth) |
| core_ack | input | 1 | Core accepts the offered interrupt |
| core_ret | input | 1 | Core returns from the handler |
| irq_valid | output | 1 | An interrupt is offered to the core |
| vec_num | output | VEC_W | Vector number of the offered interrupt |
| vec_addr | output | ADDR_W | Table address of the offered vector |
| status | output | 8 | [7] global enable, [6] handler active, [5] nonmaskable handler active |
| src_ack | output | 1 | One-cycle acknowledge to the taken source |
| src_ack_nmi | output | 1 | Acknowledge belongs to the nonmaskable source |
| src_ack_idx | output | IDX_W | Index of the acknowledged maskable source |
| nest_err | output | 1 | Disable-depth saturation pulse |

## Verification
The arbiter is driven with single-bit request patterns at both ends of the vector, and with dense and sparse multi-bit patterns. These show whether the lowest index truly wins, and whether vector number and address follow the index rather than the bit count or the highest bit. A nonmaskable edge is applied while the enable is clear and again while maskable requests compete. This separates bypass from priority, and a held-high input shows whether one event can be taken twice. Strobe sequences for nested regions, opposite strobes in the same cycle, and runs to both saturation limits tell a proper depth counter apart from a plain enable flag or one that wraps.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int STATUS_W    = 8;
  localparam int GIE_BIT     = 7;
  localparam int ACT_BIT     = 6;
  localparam int NMI_ACT_BIT = 5;
  localparam int NMI_VEC_NUM = 1;

  // vector number assigned to a maskable source index
  function automatic int vec_of_src(input int idx, input int first_vec);
    return first_vec + idx;
  endfunction

  // table address of a vector number: two words per entry, numbering from 1
  function automatic int addr_of_vec(input int vnum);
    return 2 * (vnum - 1);
  endfunction
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] first;

  // first[g] is set only for the lowest set request bit
  generate
    for (genvar g = 0; g < N; g++) begin : g_first
      if (g == 0) begin : g_lsb
        assign first[g] = req[g];
      end else begin : g_upper
        assign first[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << idx) - N'(1);

  // R3: chosen bit is set and nothing below it is set
  always_comb begin
    if (any) begin
      p_pick_lowest_r3: assert (req[idx] && ((req & below_mask) == '0));
    end
  end
endmodule

// File: rtl/vic_nmi_edge.sv
module vic_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take_nmi,
  output logic nmi_pend,
  output logic nmi_rise
);
  logic nmi_q;

  assign nmi_rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= (nmi_pend & ~take_nmi) | nmi_rise;
    end
  end

  // R8: a taken event is consumed unless a fresh edge arrives with it
  p_nmi_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && !nmi_rise) |=> !nmi_pend);
  // R8: an edge always leaves the event pending
  p_nmi_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> nmi_pend);
endmodule

// File: rtl/vic_nest_ctr.sv
module vic_nest_ctr #(
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               dec,
  output logic [DEPTH_W-1:0] depth_q,
  output logic               zero_next,
  output logic               err
);
  localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};

  logic [DEPTH_W-1:0] depth_d;
  logic               sat;

  always_comb begin
    depth_d = depth_q;
    sat     = 1'b0;
    if (inc && !dec) begin
      if (depth_q == DMAX) sat = 1'b1;
      else depth_d = depth_q + DEPTH_W'(1);
    end else if (dec && !inc) begin
      if (depth_q == '0) sat = 1'b1;
      else depth_d = depth_q - DEPTH_W'(1);
    end
  end

  assign zero_next = (depth_d == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= DEPTH_W'(1);
      err     <= 1'b0;
    end else begin
      depth_q <= depth_d;
      err     <= sat;
    end
  end

  p_no_wrap_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && depth_q == DMAX) |=> (depth_q == DMAX && err));
  p_no_wrap_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && depth_q == '0) |=> (depth_q == '0 && err));
  p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(depth_q));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC   = 8,
  parameter int FIRST_VEC = 2,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = VEC_W + 1,
  parameter int DEPTH_W   = 4,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               nmi_in,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               core_ack,
  input  logic               core_ret,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   vec_num,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [7:0]         status,
  output logic               src_ack,
  output logic               src_ack_nmi,
  output logic [IDX_W-1:0]   src_ack_idx,
  output logic               nest_err
);
  import vic_pkg::*;

  // named internal events
  logic               gie_q, active_q, nmi_act_q;
  logic               active_d, nmi_act_d, gie_d;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;
  logic               nmi_pend, nmi_rise;
  logic               take, take_nmi, ret_ev;
  logic [DEPTH_W-1:0] depth_q;
  logic               depth_zero_next;

  vic_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req (irq_req),
    .any (pick_any),
    .idx (pick_idx)
  );

  vic_nmi_edge u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_in   (nmi_in),
    .take_nmi (take_nmi),
    .nmi_pend (nmi_pend),
    .nmi_rise (nmi_rise)
  );

  vic_nest_ctr #(.DEPTH_W(DEPTH_W)) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (gie_clr),
    .dec       (gie_set),
    .depth_q   (depth_q),
    .zero_next (depth_zero_next),
    .err       (nest_err)
  );

  assign irq_valid = !active_q && (nmi_pend || (gie_q && pick_any));
  assign take      = irq_valid && core_ack;
  assign take_nmi  = take && nmi_pend;
  assign ret_ev    = core_ret && active_q;

  always_comb begin
    if (nmi_pend) vec_num = VEC_W'(NMI_VEC_NUM);
    else          vec_num = VEC_W'(vec_of_src(int'(pick_idx), FIRST_VEC));
  end
  assign vec_addr = ADDR_W'(addr_of_vec(int'(vec_num)));

  always_comb begin
    active_d  = active_q;
    nmi_act_d = nmi_act_q;
    if (take) begin
      active_d  = 1'b1;
      nmi_act_d = nmi_pend;
    end else if (ret_ev) begin
      active_d  = 1'b0;
      nmi_act_d = 1'b0;
    end
    gie_d = depth_zero_next && !active_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q       <= 1'b0;
      active_q    <= 1'b0;
      nmi_act_q   <= 1'b0;
      src_ack     <= 1'b0;
      src_ack_nmi <= 1'b0;
      src_ack_idx <= '0;
    end else begin
      gie_q       <= gie_d;
      active_q    <= active_d;
      nmi_act_q   <= nmi_act_d;
      src_ack     <= take;
      src_ack_nmi <= take_nmi;
      src_ack_idx <= (take && !nmi_pend) ? pick_idx : '0;
    end
  end

  always_comb begin
    status              = '0;
    status[GIE_BIT]     = gie_q;
    status[ACT_BIT]     = active_q;
    status[NMI_ACT_BIT] = nmi_act_q;
  end

  p_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !nmi_pend) |-> !irq_valid);
  p_take_clears_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!gie_q && active_q && !irq_valid));
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack |=> !src_ack);
  p_ret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_ev && depth_q == '0 && !gie_clr && !gie_set) |=> (gie_q && !active_q));
  p_nmi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && nmi_pend) |-> (vec_addr == '0));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  localparam int NS = 8;
  localparam int FV = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_req;
  logic       nmi_in, gie_set, gie_clr, core_ack, core_ret;
  logic       irq_valid, src_ack, src_ack_nmi, nest_err;
  logic [7:0] vec_num, status;
  logic [8:0] vec_addr;
  logic [2:0] src_ack_idx;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_in(nmi_in),
    .gie_set(gie_set), .gie_clr(gie_clr), .core_ack(core_ack),
    .core_ret(core_ret), .irq_valid(irq_valid), .vec_num(vec_num),
    .vec_addr(vec_addr), .status(status), .src_ack(src_ack),
    .src_ack_nmi(src_ack_nmi), .src_ack_idx(src_ack_idx), .nest_err(nest_err)
  );

  // request pattern and the index the lowest-wins rule selects
  localparam logic [7:0] PAT  [7] = '{8'h01, 8'h80, 8'hA4, 8'h18, 8'hFF, 8'h40, 8'hC2};
  localparam int         PIDX [7] = '{0, 7, 2, 3, 0, 6, 1};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_set();  gie_set = 1'b1;  tick(); gie_set = 1'b0;  endtask
  task automatic pulse_clr();  gie_clr = 1'b1;  tick(); gie_clr = 1'b0;  endtask
  task automatic pulse_ack();  core_ack = 1'b1; tick(); core_ack = 1'b0; endtask
  task automatic pulse_ret();  core_ret = 1'b1; tick(); core_ret = 1'b0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = 8'hFF; nmi_in = 1'b0;
    gie_set = 1'b0; gie_clr = 1'b0; core_ack = 1'b0; core_ret = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 status", int'(status), 'h00);
    chk("R1 src_ack", int'(src_ack), 0);
    chk("R1 nest_err", int'(nest_err), 0);
    chk("R2 blocked at reset", int'(irq_valid), 0);

    pulse_set();
    chk("R9 depth 1->0 sets bit7", int'(status), 'h80);
    chk("R2 enabled offers", int'(irq_valid), 1);

    // vector table walk (R3, R4)
    for (int k = 0; k < 7; k++) begin
      int ev;
      irq_req = PAT[k];
      #1;
      ev = FV + PIDX[k];
      chk("R2 valid", int'(irq_valid), 1);
      chk("R3 vec_num", int'(vec_num), ev);
      chk("R4 vec_addr", int'(vec_addr), 2 * (ev - 1));
    end
    irq_req = 8'h00;
    #1;
    chk("R2 nothing pending", int'(irq_valid), 0);

    pulse_ack();
    chk("R5 ack ignored status", int'(status), 'h80);
    chk("R6 ack ignored no pulse", int'(src_ack), 0);
    pulse_ret();
    chk("R7 stray return ignored", int'(status), 'h80);

    // take and return a maskable interrupt
    irq_req = 8'h24;
    pulse_ack();
    chk("R6 src_ack", int'(src_ack), 1);
    chk("R6 src_ack_idx", int'(src_ack_idx), 2);
    chk("R6 src_ack_nmi", int'(src_ack_nmi), 0);
    chk("R5 status in handler", int'(status), 'h40);
    chk("R5 no offer in handler", int'(irq_valid), 0);
    tick();
    chk("R6 single pulse", int'(src_ack), 0);
    pulse_ret();
    chk("R7 return restores", int'(status), 'h80);
    chk("R7 offer again", int'(irq_valid), 1);

    // nonmaskable with the enable clear
    pulse_clr();
    chk("R9 clr clears bit7", int'(status), 'h00);
    chk("R2 maskable blocked", int'(irq_valid), 0);
    nmi_in = 1'b1;
    tick();
    chk("R8 nmi bypass", int'(irq_valid), 1);
    chk("R8 nmi vec", int'(vec_num), 1);
    chk("R4 nmi addr", int'(vec_addr), 0);
    pulse_ack();
    chk("R8 src_ack_nmi", int'(src_ack_nmi), 1);
    chk("R8 nmi status", int'(status), 'h60);
    pulse_ret();
    chk("R7 return keeps disabled", int'(status), 'h00);
    chk("R8 held input taken once", int'(irq_valid), 0);
    nmi_in = 1'b0;
    tick();

    // nonmaskable wins over maskable
    pulse_set();
    irq_req = 8'h01;
    nmi_in = 1'b1;
    tick();
    chk("R8 priority over maskable", int'(vec_num), 1);
    pulse_ack();
    pulse_ret();
    nmi_in = 1'b0;
    tick();
    chk("R3 maskable after nmi", int'(vec_num), FV);

    // nested disable levels
    irq_req = 8'h00;
    pulse_clr();
    pulse_clr();
    pulse_set();
    chk("R9 inner enable keeps off", int'(status), 'h00);
    pulse_set();
    chk("R9 outer enable", int'(status), 'h80);
    pulse_set();
    chk("R10 underflow err", int'(nest_err), 1);
    chk("R10 underflow keeps enable", int'(status), 'h80);
    tick();
    chk("R10 err one cycle", int'(nest_err), 0);
    gie_set = 1'b1; gie_clr = 1'b1;
    tick();
    gie_set = 1'b0; gie_clr = 1'b0;
    chk("R9 both strobes no change", int'(status), 'h80);
    chk("R9 both strobes no err", int'(nest_err), 0);

    // disable inside a handler holds off the restore
    irq_req = 8'h10;
    pulse_ack();
    irq_req = 8'h00;
    pulse_clr();
    pulse_ret();
    chk("R9 return with depth 1", int'(status), 'h00);
    pulse_set();
    chk("R9 enable after return", int'(status), 'h80);

    // upper saturation
    for (int k = 0; k < 15; k++) pulse_clr();
    chk("R10 no err at limit", int'(nest_err), 0);
    pulse_clr();
    chk("R10 overflow err", int'(nest_err), 1);
    for (int k = 0; k < 14; k++) pulse_set();
    chk("R10 depth held at 15", int'(status), 'h00);
    pulse_set();
    chk("R10 reenabled after 15", int'(status), 'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule